// File: doc/BRIEF.md
# PHY Management Register File

This block is the register side of an Ethernet PHY's management plane. A host reaches it through a parallel register port. The port has a 5-bit register number, 16-bit write data, and one-cycle read and write strobes. Read data comes back on a registered response one cycle later.

The block holds three kinds of register:

- **Basic control register.** Its top bit starts a timed soft reset that clears itself.
- **Extended register window.** A two-register protocol reaches extended device registers. An access-control register selects a function and a device number. An access-data register then carries either an offset or the data at the selected offset.
- **Debug window.** A separate pair of registers gives an offset and the data at that offset.

Two configuration outputs come from these windows: a 2-bit reference-clock select and an RGMII transmit-clock delay enable. A soft reset returns the control register to its default value and leaves the extended and debug configuration as it was. A hardware reset clears everything.

The read response has a valid flag and no ready. The host must take `rd_data` in the cycle that `rd_valid` is high; the block never stalls a strobe. Only one strobe may be high in a cycle.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset, register 0x00 reads `CTRL_DEF` (default 0x1140) and register 0x01 reads `STAT_DEF` (default 0x7949). Registers 0x0D and 0x1D read 0x0000, and `soft_rst_busy`, `clk_sel` and `tx_clk_dly_en` are all 0.
- R2: A read strobe sampled at a clock edge makes `rd_valid` high for exactly the following cycle. In that cycle `rd_data` holds the addressed register's value from before that edge.
- R3: While no soft reset is in progress, a write to 0x00 with bit 15 clear stores bits 14:0, and they read back unchanged.
- R4: A write to 0x00 with bit 15 set, made while idle, raises `soft_rst_busy` for exactly `RST_CYCLES` cycles. During that time bit 15 of 0x00 reads 1 and bits 14:0 keep their earlier value. When it ends, 0x00 reads `CTRL_DEF` with bit 15 clear.
- R5: Every write to 0x00 whose edge falls while `soft_rst_busy` is high is discarded. This includes the edge on which the reset completes.
- R6: Register 0x0D holds a function code in bits 15:14 and a device number in bits 4:0; all other bits read 0. With function 00, a write to 0x0E sets the 16-bit extended offset and a read of 0x0E returns that offset.
- R7: With function 01, data accesses to 0x0E reach the extended register at device 7, offset 0x8016. Bits 4:3 of that register drive `clk_sel` (00 = 25 MHz, 01 = 50 MHz, 10 = 62.5 MHz, 11 = 125 MHz). It reads back as `{11'b0, clk_sel, 3'b0}`, and the offset does not change.
- R8: With function 10, each data read or write of 0x0E adds 1 to the offset after the access. With function 11, only writes do so. The offset wraps from 0xFFFF to 0x0000.
- R9: A data access to any other device and offset pair reads 0x0000, and a write to it leaves `clk_sel` unchanged.
- R10: Register 0x1D holds a 6-bit debug offset in bits 5:0. When that offset is 5, a write to 0x1E sets `tx_clk_dly_en` from bit 8, and a read returns `{7'b0, tx_clk_dly_en, 8'b0}`. At any other offset, 0x1E reads 0 and writes have no effect.
- R11: A soft reset leaves `clk_sel`, `tx_clk_dly_en`, register 0x0D, the extended offset and the debug offset unchanged. A hardware reset returns all of them to 0.
- R12: Registers with no assignment read 0x0000, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_addr | input | 5 | Register number of the access |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| rd_data | output | 16 | Read response data |
| rd_valid | output | 1 | Read response valid, one cycle after `rd_en` |
| soft_rst_busy | output | 1 | High while a soft reset is running |
| clk_sel | output | 2 | Reference clock select |
| tx_clk_dly_en | output | 1 | RGMII transmit clock delay enable |

## Verification
Two functions can meet on the same edge: the soft-reset timer expiring, and a host write to the control register. The bench starts a reset and counts negedges so that a write is sampled on exactly the edge where `soft_rst_busy` falls. It then expects 0x00 to read the default value, not the written data, and a write one edge later to be stored. A second pairing is a data access and the post-increment it triggers. This is judged by switching back to function 00 and reading the offset.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'h01;
  localparam logic [ADDR_W-1:0] A_XCTL    = 5'h0D;
  localparam logic [ADDR_W-1:0] A_XDAT    = 5'h0E;
  localparam logic [ADDR_W-1:0] A_DBG_OFS = 5'h1D;
  localparam logic [ADDR_W-1:0] A_DBG_DAT = 5'h1E;

  typedef enum logic [1:0] {
    XF_OFFSET  = 2'b00,
    XF_DATA    = 2'b01,
    XF_DATA_RW = 2'b10,
    XF_DATA_W  = 2'b11
  } xfunc_e;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int              RST_CYCLES = 1000000,
  parameter logic [DATA_W-1:0] CTRL_DEF = 16'h1140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic [DATA_W-2:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF[DATA_W-2:0];
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        ctrl_q <= CTRL_DEF[DATA_W-2:0];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (wr) begin
      if (wdata[DATA_W-1]) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        ctrl_q <= wdata[DATA_W-2:0];
      end
    end
  end

  assign rdata = {busy_q, ctrl_q};
  assign busy  = busy_q;

  // R4: busy only starts from a write with the reset bit set
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr && wdata[DATA_W-1]));
  // R4: the end of a soft reset leaves the defaults in place
  p_end_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (ctrl_q == CTRL_DEF[DATA_W-2:0]));
  // R5: stored bits do not move while the reset continues
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(ctrl_q)));
endmodule

// File: rtl/phy_mgmt_ext.sv
module phy_mgmt_ext
  import phy_mgmt_pkg::*;
#(
  parameter int              DEV_W   = 5,
  parameter logic [4:0]      CFG_DEV = 5'd7,
  parameter logic [DATA_W-1:0] CFG_OFS = 16'h8016,
  parameter int              SEL_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic [1:0]        sel
);
  xfunc_e             fn_q;
  logic [DEV_W-1:0]   dev_q;
  logic [DATA_W-1:0]  ofs_q;
  logic [1:0]         sel_q;
  logic               data_mode, hit, inc;

  assign data_mode = (fn_q != XF_OFFSET);
  assign hit       = (dev_q == CFG_DEV[DEV_W-1:0]) && (ofs_q == CFG_OFS);
  assign inc       = data_mode &&
                     ((dat_wr && fn_q[1]) || (dat_rd && fn_q == XF_DATA_RW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= XF_OFFSET;
      dev_q <= '0;
      ofs_q <= '0;
      sel_q <= '0;
    end else begin
      if (ctl_wr) begin
        fn_q  <= xfunc_e'(wdata[DATA_W-1:DATA_W-2]);
        dev_q <= wdata[DEV_W-1:0];
      end
      if (dat_wr && !data_mode) ofs_q <= wdata;
      else if (inc)             ofs_q <= ofs_q + 1'b1;
      if (dat_wr && data_mode && hit) sel_q <= wdata[SEL_LSB+1:SEL_LSB];
    end
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[DATA_W-1:DATA_W-2] = fn_q;
    ctl_rdata[DEV_W-1:0] = dev_q;
    dat_rdata = '0;
    if (!data_mode)  dat_rdata = ofs_q;
    else if (hit)    dat_rdata[SEL_LSB+1:SEL_LSB] = sel_q;
  end

  assign sel = sel_q;

  // R8: incrementing data writes advance the offset by one
  p_postinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && fn_q[1]) |=> (ofs_q == $past(ofs_q) + 16'd1));
  // R8: a read in write-only increment mode leaves the offset
  p_noinc_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && fn_q == XF_DATA_W) |=> $stable(ofs_q));
  // R9: data writes off the configured location leave the clock select
  p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !hit) |=> $stable(sel_q));
endmodule

// File: rtl/phy_mgmt_dbg.sv
module phy_mgmt_dbg
  import phy_mgmt_pkg::*;
#(
  parameter int              OFS_W   = 6,
  parameter logic [5:0]      DLY_OFS = 6'd5,
  parameter int              DLY_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofs_wr,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ofs_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              dly_en
);
  logic [OFS_W-1:0] ofs_q;
  logic             dly_q;
  logic             hit;

  assign hit = (ofs_q == DLY_OFS[OFS_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      dly_q <= 1'b0;
    end else begin
      if (ofs_wr)        ofs_q <= wdata[OFS_W-1:0];
      if (dat_wr && hit) dly_q <= wdata[DLY_BIT];
    end
  end

  always_comb begin
    ofs_rdata = '0;
    ofs_rdata[OFS_W-1:0] = ofs_q;
    dat_rdata = '0;
    dat_rdata[DLY_BIT] = hit & dly_q;
  end

  assign dly_en = dly_q;

  // R10: writes at other debug offsets do not touch the delay enable
  p_dbg_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !hit) |=> $stable(dly_q));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int              RST_CYCLES = 1000000,
  parameter logic [15:0]     CTRL_DEF   = 16'h1140,
  parameter logic [15:0]     STAT_DEF   = 16'h7949
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        soft_rst_busy,
  output logic [1:0]  clk_sel,
  output logic        tx_clk_dly_en
);
  logic [DATA_W-1:0] ctrl_rd, xctl_rd, xdat_rd, dofs_rd, ddat_rd;
  logic [DATA_W-1:0] mux_rd, rd_q;
  logic              rv_q;

  phy_mgmt_ctrl #(.RST_CYCLES(RST_CYCLES), .CTRL_DEF(CTRL_DEF)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_en && reg_addr == A_CTRL), .wdata(wr_data),
    .rdata(ctrl_rd), .busy(soft_rst_busy)
  );

  phy_mgmt_ext u_ext (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(wr_en && reg_addr == A_XCTL),
    .dat_wr(wr_en && reg_addr == A_XDAT),
    .dat_rd(rd_en && reg_addr == A_XDAT),
    .wdata(wr_data), .ctl_rdata(xctl_rd), .dat_rdata(xdat_rd), .sel(clk_sel)
  );

  phy_mgmt_dbg u_dbg (
    .clk(clk), .rst_n(rst_n),
    .ofs_wr(wr_en && reg_addr == A_DBG_OFS),
    .dat_wr(wr_en && reg_addr == A_DBG_DAT),
    .wdata(wr_data), .ofs_rdata(dofs_rd), .dat_rdata(ddat_rd),
    .dly_en(tx_clk_dly_en)
  );

  always_comb begin
    unique case (reg_addr)
      A_CTRL:    mux_rd = ctrl_rd;
      A_STAT:    mux_rd = STAT_DEF;
      A_XCTL:    mux_rd = xctl_rd;
      A_XDAT:    mux_rd = xdat_rd;
      A_DBG_OFS: mux_rd = dofs_rd;
      A_DBG_DAT: mux_rd = ddat_rd;
      default:   mux_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= rd_en;
      if (rd_en) rd_q <= mux_rd;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rv_q;

  // R2: a read strobe yields exactly one valid cycle
  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R11: a running soft reset never moves the debug delay on its own
  p_keep_dly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_busy && !wr_en) |=> $stable(tx_clk_dly_en));
endmodule

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid, soft_rst_busy, tx_clk_dly_en;
  logic [1:0]  clk_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_regs #(.RST_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .soft_rst_busy(soft_rst_busy), .clk_sel(clk_sel), .tx_clk_dly_en(tx_clk_dly_en)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " rd_valid R2"}, {15'b0, rd_valid}, 16'd1);
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected response %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 busy", {15'b0, soft_rst_busy}, 16'd0);
    check("R1 clk_sel", {14'b0, clk_sel}, 16'd0);
    check("R1 dly", {15'b0, tx_clk_dly_en}, 16'd0);
    rd(5'h00, 16'h1140, "R1 ctrl default");
    rd(5'h01, 16'h7949, "R1 status default");
    rd(5'h0D, 16'h0000, "R1 xctl default");
    rd(5'h1D, 16'h0000, "R1 dbg ofs default");
    @(negedge clk);
    check("R2 rd_valid drops", {15'b0, rd_valid}, 16'd0);

    // R3 control bits
    wr(5'h00, 16'h0100); rd(5'h00, 16'h0100, "R3 ctrl wr a");
    wr(5'h00, 16'h3100); rd(5'h00, 16'h3100, "R3 ctrl wr b");

    // R12 unassigned
    wr(5'h05, 16'hBEEF); rd(5'h05, 16'h0000, "R12 unassigned");

    // R4/R5 soft reset with reads during it
    wr(5'h00, 16'h8000);
    check("R4 busy raised", {15'b0, soft_rst_busy}, 16'd1);
    rd(5'h00, 16'hB100, "R4 bit15 during reset");
    wr(5'h00, 16'h0000);
    rd(5'h00, 16'hB100, "R5 write in reset discarded");
    repeat (10) @(negedge clk);
    rd(5'h00, 16'h1140, "R4 default after reset");

    // R4/R5 collision: write on the completion edge
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h8000);
    check("R4 busy at cycle 1", {15'b0, soft_rst_busy}, 16'd1);
    repeat (RST_CYC-2) @(negedge clk);
    check("R4 busy at last cycle", {15'b0, soft_rst_busy}, 16'd1);
    wr(5'h00, 16'h2000);
    check("R4 busy ended", {15'b0, soft_rst_busy}, 16'd0);
    rd(5'h00, 16'h1140, "R5 completion-edge write discarded");
    wr(5'h00, 16'h2000);
    rd(5'h00, 16'h2000, "R3 write after reset accepted");

    // R6 offset mode
    wr(5'h0D, 16'h0007); rd(5'h0D, 16'h0007, "R6 xctl readback");
    wr(5'h0E, 16'h8016); rd(5'h0E, 16'h8016, "R6 offset readback");

    // R7 data mode, no increment
    wr(5'h0D, 16'h4007); rd(5'h0D, 16'h4007, "R6 xctl fn01");
    rd(5'h0E, 16'h0000, "R7 initial field");
    wr(5'h0E, 16'h0008);
    check("R7 clk_sel 50M", {14'b0, clk_sel}, 16'd1);
    rd(5'h0E, 16'h0008, "R7 readback 01");
    wr(5'h0E, 16'hFFFF);
    check("R7 clk_sel 125M", {14'b0, clk_sel}, 16'd3);
    rd(5'h0E, 16'h0018, "R7 only field kept");
    wr(5'h0E, 16'h0010);
    check("R7 clk_sel 62.5M", {14'b0, clk_sel}, 16'd2);
    wr(5'h0D, 16'h0007); rd(5'h0E, 16'h8016, "R7 offset unchanged");

    // R8 increment on read and write
    wr(5'h0E, 16'h8015); wr(5'h0D, 16'h8007);
    rd(5'h0E, 16'h0000, "R8 fn10 read miss");
    rd(5'h0E, 16'h0010, "R8 fn10 advanced to hit");
    wr(5'h0D, 16'h0007); rd(5'h0E, 16'h8017, "R8 fn10 offset after reads");
    // R8 increment on write only
    wr(5'h0E, 16'h8016); wr(5'h0D, 16'hC007);
    rd(5'h0E, 16'h0010, "R8 fn11 read a");
    rd(5'h0E, 16'h0010, "R8 fn11 read no inc");
    wr(5'h0E, 16'h0008);
    check("R8 fn11 write hit", {14'b0, clk_sel}, 16'd1);
    wr(5'h0E, 16'h0018);
    check("R9 miss write ignored", {14'b0, clk_sel}, 16'd1);
    wr(5'h0D, 16'h0007); rd(5'h0E, 16'h8018, "R8 fn11 offset after writes");
    wr(5'h0E, 16'hFFFF); wr(5'h0D, 16'hC007); wr(5'h0E, 16'h0000);
    wr(5'h0D, 16'h0007); rd(5'h0E, 16'h0000, "R8 offset wrap");

    // R9 wrong device
    wr(5'h0D, 16'h0003); wr(5'h0E, 16'h8016); wr(5'h0D, 16'h4003);
    wr(5'h0E, 16'h0018);
    check("R9 other device write", {14'b0, clk_sel}, 16'd1);
    rd(5'h0E, 16'h0000, "R9 other device read");

    // R10 debug window
    wr(5'h1D, 16'h0005); rd(5'h1D, 16'h0005, "R10 dbg ofs");
    wr(5'h1E, 16'h0100);
    check("R10 dly set", {15'b0, tx_clk_dly_en}, 16'd1);
    rd(5'h1E, 16'h0100, "R10 dbg readback");
    wr(5'h1D, 16'h0006); wr(5'h1E, 16'h0000);
    check("R10 other ofs no effect", {15'b0, tx_clk_dly_en}, 16'd1);
    rd(5'h1E, 16'h0000, "R10 other ofs reads 0");
    wr(5'h1D, 16'h0045); rd(5'h1D, 16'h0005, "R10 ofs width");
    rd(5'h1E, 16'h0100, "R10 truncated ofs hits");

    // R11 soft reset keeps, hardware reset clears
    wr(5'h00, 16'h8000);
    repeat (RST_CYC+4) @(negedge clk);
    check("R11 clk_sel kept", {14'b0, clk_sel}, 16'd1);
    check("R11 dly kept", {15'b0, tx_clk_dly_en}, 16'd1);
    rd(5'h0D, 16'h4003, "R11 xctl kept");
    rd(5'h1D, 16'h0005, "R11 dbg ofs kept");
    wr(5'h0D, 16'h0003); rd(5'h0E, 16'h8016, "R11 offset kept");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 hw clk_sel", {14'b0, clk_sel}, 16'd0);
    check("R11 hw dly", {15'b0, tx_clk_dly_en}, 16'd0);
    rd(5'h1D, 16'h0000, "R11 hw dbg ofs");
    rd(5'h0E, 16'h0000, "R11 hw offset");
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule